// File: doc/BRIEF.md
# Block Write Masking and Timing Engine

This block performs the graphics-memory block write. One command takes a 32-bit color value and copies it into eight neighbouring words of a small internal memory with two banks. Each of the eight words gets its own per-bit write enable, which is the AND of three masks. The first is a column/byte mask read from the 32 data-pin bits of the command. The second is a 4-bit per-byte mask (DQM) given with the command. The third is a per-bit write-mask register that software loads.

A block write keeps the array busy for a recovery window. The block checks every command that follows and decides whether to accept it. A command that breaks a spacing rule is dropped and has no effect. In the cycle after it, a one-cycle violation flag is raised. The color and write-mask registers are loaded with a separate load command. A combinational read port returns any stored word by bank and column, so the written contents can be inspected.

Top module: `bw_engine`

## Requirements
- R1: An accepted block write (op code 3) with bank B and column C changes only the eight words of bank B whose column shares the upper bits of C, from column (C with its low three bits cleared) upward. All other words keep their value.
- R2: Data-pin bit 8*b+i enables byte b (b = 0..3, bits 8*b to 8*b+7) of the i-th word of the block (i = 0..7). A 1 writes the color byte there, and a 0 keeps the stored byte.
- R3: A DQM bit b set to 1 keeps byte b of all eight words unchanged, whatever the data pins say.
- R4: Write-mask register bit k set to 1 lets bit k of every word be written. A 0 keeps bit k unchanged in all eight words.
- R5: A load command (op code 4) with select 0 loads the color register, and with select 1 loads the write-mask register. After reset the color register is 0 and the write-mask register is all ones.
- R6: In the TBWC-1 cycles after an accepted block write (default 1 cycle), these commands are rejected: block write, load, and activate (op 1) or precharge (op 2) to the same bank. NOP (op 0) is always accepted.
- R7: Activate and precharge to the other bank are accepted inside the window of R6.
- R8: A precharge to the bank of a block write is rejected until TBPL cycles (default 3) have passed since that block write. It is accepted from that cycle on.
- R9: A rejected command changes neither the memory nor any register. The violation flag is high in exactly the one cycle after each rejected command.
- R10: After reset the violation flag is low and every memory word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | 0 NOP, 1 activate, 2 precharge, 3 block write, 4 load register |
| cmd_bank | input | 1 | Target bank |
| cmd_col | input | 5 | Column address for block write |
| cmd_data | input | 32 | Data-pin mask for block write, or value for load |
| cmd_dqm | input | 4 | Per-byte mask, 1 blocks the byte |
| cmd_sel | input | 1 | Load target: 0 color, 1 write mask |
| cmd_accept | output | 1 | The present command is legal and takes effect |
| viol | output | 1 | The previous cycle's command was rejected |
| rd_bank | input | 1 | Read bank |
| rd_col | input | 5 | Read column |
| rd_data | output | 32 | Stored word at the read address |

## Verification
The bench targets the transposed pin mapping. It enables single (word, byte) pairs at the corners of the block: word 0 byte 0, word 7 byte 3 and word 5 byte 1. A design that swapped the word and byte indices would write the wrong bytes. The bench also uses a non-aligned column, so a design that failed to clear the low address bits would spill into the next block. Masked writes over data already in memory show whether unmasked bits are kept or cleared. On the timing side, the bench checks precharge to the block-write bank at exactly TBPL-1 and TBPL cycles after the block write. It also checks other-bank commands inside the busy window and a load rejected in that window, whose effect would show up in a later write. An off-by-one counter, or a rule that ignored the bank, would accept or reject the wrong cycle.

// File: rtl/bw_pkg.sv
package bw_pkg;
   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_ACT   = 3'd1,
      OP_PRE   = 3'd2,
      OP_BLKW  = 3'd3,
      OP_LDREG = 3'd4
   } bw_op_e;
endpackage

// File: rtl/bw_timing_guard.sv
module bw_timing_guard
   import bw_pkg::*;
#(
   parameter int NBANK = 2,
   parameter int TBWC  = 2,
   parameter int TBPL  = 3,
   localparam int BANK_W = $clog2(NBANK),
   localparam int TMAX   = (TBWC > TBPL) ? TBWC : TBPL,
   localparam int CW     = $clog2(TMAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [BANK_W-1:0] cmd_bank,
   output logic              legal,
   output logic              viol
);
   bw_op_e              op_e;
   logic [CW-1:0]       busy_q;
   logic [CW-1:0]       bpl_q [NBANK];
   logic [BANK_W-1:0]   last_bank_q;
   logic                in_window;
   logic                same_bank;
   logic                acc_blkw;

   assign op_e      = bw_op_e'(cmd_op);
   assign in_window = (busy_q != '0);
   assign same_bank = (cmd_bank == last_bank_q);

   always_comb begin
      case (op_e)
         OP_NOP:   legal = 1'b1;
         OP_ACT:   legal = !in_window || !same_bank;
         OP_PRE:   legal = (!in_window || !same_bank) && (bpl_q[cmd_bank] == '0);
         OP_BLKW,
         OP_LDREG: legal = !in_window;
         default:  legal = 1'b1;
      endcase
   end

   assign acc_blkw = cmd_valid && legal && (op_e == OP_BLKW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= '0;
         last_bank_q <= '0;
         viol        <= 1'b0;
      end else begin
         viol <= cmd_valid && !legal;
         if (acc_blkw) begin
            busy_q      <= CW'(TBWC - 1);
            last_bank_q <= cmd_bank;
         end else if (busy_q != '0) begin
            busy_q <= busy_q - 1'b1;
         end
      end
   end

   for (genvar bk = 0; bk < NBANK; bk++) begin : g_bank_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bpl_q[bk] <= '0;
         end else if (acc_blkw && (cmd_bank == BANK_W'(bk))) begin
            bpl_q[bk] <= CW'(TBPL - 1);
         end else if (bpl_q[bk] != '0) begin
            bpl_q[bk] <= bpl_q[bk] - 1'b1;
         end
      end
   end
endmodule

// File: rtl/bw_mask_gen.sv
module bw_mask_gen #(
   parameter int NLOC   = 8,
   parameter int NBYTE  = 4,
   parameter int BYTE_W = 8,
   localparam int W = NBYTE * BYTE_W
) (
   input  logic [W-1:0]            pins,
   input  logic [NBYTE-1:0]        dqm,
   input  logic [W-1:0]            wmask,
   output logic [NLOC-1:0][W-1:0]  en
);
   for (genvar i = 0; i < NLOC; i++) begin : g_loc
      for (genvar b = 0; b < NBYTE; b++) begin : g_byte
         logic byte_on;
         assign byte_on = pins[b*NLOC + i] & ~dqm[b];
         assign en[i][b*BYTE_W +: BYTE_W] = {BYTE_W{byte_on}} & wmask[b*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/bw_array.sv
module bw_array #(
   parameter int NBANK = 2,
   parameter int NCOL  = 32,
   parameter int NLOC  = 8,
   parameter int W     = 32,
   localparam int BANK_W = $clog2(NBANK),
   localparam int COL_W  = $clog2(NCOL),
   localparam int DEPTH  = NBANK * NCOL
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [BANK_W-1:0]       wr_bank,
   input  logic [COL_W-1:0]        wr_col,
   input  logic [W-1:0]            color,
   input  logic [NLOC-1:0][W-1:0]  en,
   input  logic [BANK_W-1:0]       rd_bank,
   input  logic [COL_W-1:0]        rd_col,
   output logic [W-1:0]            rd_data
);
   logic [W-1:0] mem_q [DEPTH];
   logic [COL_W-1:0] col_hi;

   assign col_hi = wr_col | COL_W'(NLOC - 1);

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam int BK  = w / NCOL;
      localparam int CL  = w % NCOL;
      localparam int LOC = CL % NLOC;
      logic hit;
      assign hit = wr_en && (wr_bank == BANK_W'(BK)) && (col_hi == COL_W'(CL | (NLOC - 1)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_q[w] <= '0;
         end else if (hit) begin
            mem_q[w] <= (mem_q[w] & ~en[LOC]) | (color & en[LOC]);
         end
      end
   end

   assign rd_data = mem_q[{rd_bank, rd_col}];
endmodule

// File: rtl/bw_engine.sv
module bw_engine
   import bw_pkg::*;
#(
   parameter int NBANK  = 2,
   parameter int NCOL   = 32,
   parameter int NLOC   = 8,
   parameter int NBYTE  = 4,
   parameter int BYTE_W = 8,
   parameter int TBWC   = 2,
   parameter int TBPL   = 3,
   localparam int W      = NBYTE * BYTE_W,
   localparam int BANK_W = $clog2(NBANK),
   localparam int COL_W  = $clog2(NCOL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic [W-1:0]      cmd_data,
   input  logic [NBYTE-1:0]  cmd_dqm,
   input  logic              cmd_sel,
   output logic              cmd_accept,
   output logic              viol,
   input  logic [BANK_W-1:0] rd_bank,
   input  logic [COL_W-1:0]  rd_col,
   output logic [W-1:0]      rd_data
);
   if (NLOC != BYTE_W) begin : g_bad_map
      $error("bw_engine: NLOC must equal BYTE_W for the pin mapping");
   end
   if (NBANK < 2 || (1 << BANK_W) != NBANK) begin : g_bad_bank
      $error("bw_engine: NBANK must be a power of two, at least 2");
   end
   if ((1 << COL_W) != NCOL || NCOL <= NLOC || (NLOC & (NLOC - 1)) != 0) begin : g_bad_col
      $error("bw_engine: NCOL and NLOC must be powers of two with NCOL > NLOC");
   end
   if (TBWC < 1 || TBPL < 1) begin : g_bad_time
      $error("bw_engine: TBWC and TBPL must be at least 1");
   end

   logic                   legal;
   logic                   acc_blkw;
   logic                   acc_load;
   logic [W-1:0]           color_q;
   logic [W-1:0]           wmask_q;
   logic [NLOC-1:0][W-1:0] loc_en;

   bw_timing_guard #(.NBANK(NBANK), .TBWC(TBWC), .TBPL(TBPL)) u_guard (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_bank(cmd_bank), .legal(legal), .viol(viol)
   );

   assign cmd_accept = cmd_valid && legal;
   assign acc_blkw   = cmd_accept && (bw_op_e'(cmd_op) == OP_BLKW);
   assign acc_load   = cmd_accept && (bw_op_e'(cmd_op) == OP_LDREG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         color_q <= '0;
         wmask_q <= '1;
      end else if (acc_load) begin
         if (cmd_sel) wmask_q <= cmd_data;
         else         color_q <= cmd_data;
      end
   end

   bw_mask_gen #(.NLOC(NLOC), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_mask (
      .pins(cmd_data), .dqm(cmd_dqm), .wmask(wmask_q), .en(loc_en)
   );

   bw_array #(.NBANK(NBANK), .NCOL(NCOL), .NLOC(NLOC), .W(W)) u_arr (
      .clk(clk), .rst_n(rst_n), .wr_en(acc_blkw), .wr_bank(cmd_bank),
      .wr_col(cmd_col), .color(color_q), .en(loc_en),
      .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data)
   );
endmodule

// File: rtl/bw_engine_chk.sv
module bw_engine_chk #(
   parameter int BANK_W = 1,
   parameter int COL_W  = 5,
   parameter int W      = 32,
   parameter int TBWC   = 2,
   parameter int TBPL   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic [BANK_W-1:0] cmd_bank,
   input logic              cmd_accept,
   input logic              viol,
   input logic [BANK_W-1:0] rd_bank,
   input logic [COL_W-1:0]  rd_col,
   input logic [W-1:0]      rd_data
);
   logic acc_blkw;
   assign acc_blkw = cmd_valid && cmd_accept && (cmd_op == 3'd3);

   // R1: without a block write the memory contents do not move
   a_r1_mem_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_blkw ##1 ($stable(rd_bank) && $stable(rd_col))) |-> $stable(rd_data));

   a_r6_window_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      ((TBWC > 1) && acc_blkw) |=> !(cmd_accept && (cmd_op == 3'd3 || cmd_op == 3'd4)));

   a_r7_other_bank_ok: assert property (@(posedge clk) disable iff (!rst_n)
      acc_blkw |=> (!(cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2) &&
                      cmd_bank != $past(cmd_bank)) || cmd_accept));

   a_r8_early_pre: assert property (@(posedge clk) disable iff (!rst_n)
      ((TBPL > 1) && acc_blkw) |=> !(cmd_accept && cmd_op == 3'd2 && cmd_bank == $past(cmd_bank)));

   a_r9_viol_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_accept) |=> viol);

   a_r9_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> $past(cmd_valid && !cmd_accept));
endmodule

bind bw_engine bw_engine_chk #(
   .BANK_W(BANK_W), .COL_W(COL_W), .W(W), .TBWC(TBWC), .TBPL(TBPL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_bank(cmd_bank), .cmd_accept(cmd_accept), .viol(viol),
   .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data)
);

// File: tb/bw_engine_tb_top.sv
module bw_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic        cmd_bank = 1'b0;
   logic [4:0]  cmd_col = 5'd0;
   logic [31:0] cmd_data = 32'd0;
   logic [3:0]  cmd_dqm = 4'd0;
   logic        cmd_sel = 1'b0;
   logic        cmd_accept, viol;
   logic        rd_bank = 1'b0;
   logic [4:0]  rd_col = 5'd0;
   logic [31:0] rd_data;

   int checks = 0;
   int fails = 0;
   logic [31:0] mdl [64];
   logic [31:0] m_color = 32'd0;
   logic [31:0] m_wmask = 32'hFFFF_FFFF;

   always #5 clk = ~clk;

   bw_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_data(cmd_data),
      .cmd_dqm(cmd_dqm), .cmd_sel(cmd_sel), .cmd_accept(cmd_accept),
      .viol(viol), .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_blkw(input logic bk, input logic [4:0] col, input logic [31:0] d, input logic [3:0] m);
      for (int i = 0; i < 8; i++) begin
         int idx = bk * 32 + (col & 5'h18) + i;
         for (int k = 0; k < 32; k++) begin
            int b = k / 8;
            if (d[8*b + i] && !m[b] && m_wmask[k]) mdl[idx][k] = m_color[k];
         end
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic bk, input logic [4:0] col,
                        input logic [31:0] d, input logic [3:0] m, input logic s,
                        input logic exp_acc, input string req);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_bank = bk; cmd_col = col;
      cmd_data = d; cmd_dqm = m; cmd_sel = s;
      #1;
      chk(cmd_accept == exp_acc, req, {31'd0, cmd_accept}, {31'd0, exp_acc});
      @(posedge clk);
      #1;
      chk(viol == !exp_acc, "R9 viol flag", {31'd0, viol}, {31'd0, !exp_acc});
      if (exp_acc && op == 3'd3) model_blkw(bk, col, d, m);
      if (exp_acc && op == 3'd4) begin
         if (s) m_wmask = d;
         else   m_color = d;
      end
   endtask

   task automatic nop(input int n);
      for (int j = 0; j < n; j++) issue(3'd0, 1'b0, 5'd0, 32'd0, 4'd0, 1'b0, 1'b1, "R6 nop");
   endtask

   task automatic check_mem(input string req);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
      for (int w = 0; w < 64; w++) begin
         rd_bank = w[5]; rd_col = w[4:0];
         #0.1;
         chk(rd_data === mdl[w], req, rd_data, mdl[w]);
      end
   endtask

   task automatic t_reset;
      chk(viol == 1'b0, "R10 viol", {31'd0, viol}, 32'd0);
      check_mem("R10 mem zero");
   endtask

   task automatic t_basic;
      issue(3'd4, 0, 0, 32'hA5C3_0F96, 0, 0, 1, "R5 load color");
      issue(3'd3, 0, 5'd13, 32'hFFFF_FFFF, 0, 0, 1, "R1 blkw");
      nop(2);
      check_mem("R1 aligned block");
   endtask

   task automatic t_pinmap;
      issue(3'd3, 1, 5'd2, 32'h8000_2001, 0, 0, 1, "R2 blkw");
      nop(2);
      check_mem("R2 pin map");
   endtask

   task automatic t_dqm;
      issue(3'd4, 0, 0, 32'h1234_5678, 0, 0, 1, "R5 load color");
      issue(3'd3, 0, 5'd16, 32'hFFFF_FFFF, 4'b0101, 0, 1, "R3 blkw");
      nop(2);
      check_mem("R3 dqm");
   endtask

   task automatic t_wmask;
      issue(3'd4, 0, 0, 32'h0F0F_00FF, 0, 1, 1, "R5 load wmask");
      issue(3'd4, 0, 0, 32'hFFFF_FFFF, 0, 0, 1, "R5 load color");
      issue(3'd3, 1, 5'd31, 32'hFFFF_FFFF, 0, 0, 1, "R4 blkw");
      nop(2);
      issue(3'd3, 0, 5'd8, 32'h00FF_FF00, 0, 0, 1, "R4 blkw overwrite");
      nop(2);
      check_mem("R4 wmask");
   endtask

   task automatic t_window;
      issue(3'd3, 0, 5'd0, 32'hFFFF_FFFF, 0, 0, 1, "R6 blkw");
      issue(3'd3, 1, 5'd8, 32'hFFFF_FFFF, 0, 0, 0, "R6 blkw in window");
      nop(2);
      issue(3'd3, 0, 5'd0, 32'h0000_00FF, 0, 0, 1, "R6 blkw");
      issue(3'd4, 0, 0, 32'hDEAD_BEEF, 0, 0, 0, "R6 load in window");
      nop(2);
      issue(3'd3, 1, 5'd8, 32'h0F0F_0F0F, 0, 0, 1, "R9 blkw after rejected load");
      issue(3'd1, 1, 0, 0, 0, 0, 0, "R6 act same bank");
      nop(2);
      check_mem("R9 no effect");
   endtask

   task automatic t_banks;
      issue(3'd3, 0, 5'd24, 32'h0000_FFFF, 0, 0, 1, "R7 blkw");
      issue(3'd1, 1, 0, 0, 0, 0, 1, "R7 act other bank");
      issue(3'd2, 0, 0, 0, 0, 0, 0, "R8 pre same bank early");
      issue(3'd2, 0, 0, 0, 0, 0, 1, "R8 pre same bank at TBPL");
      issue(3'd3, 1, 5'd16, 32'hFFFF_0000, 0, 0, 1, "R7 blkw");
      issue(3'd2, 0, 0, 0, 0, 0, 1, "R7 pre other bank");
      issue(3'd2, 1, 0, 0, 0, 0, 0, "R8 pre same bank early");
      issue(3'd2, 1, 0, 0, 0, 0, 1, "R8 pre same bank at TBPL");
      check_mem("R7 memory");
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      for (int w = 0; w < 64; w++) mdl[w] = 32'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_pinmap();
      t_dqm();
      t_wmask();
      t_window();
      t_banks();
      summary();
   end
endmodule